// File: doc/BRIEF.md
# SDRAM Power-Up, Access and Refresh Sequencer

This block drives a single-rank, four-bank SDRAM with a 12-bit address bus. Once reset is released it runs the mandatory start-up routine on its own: a long quiet period with clock enable held high, a close of every bank, two refresh cycles and the programming of the device's mode register. After that it serves one read or one write at a time from a plain valid/acknowledge request port.

Every access opens its row, issues a one-beat column command that closes the row by itself, and then waits until the bank is idle again. Only then does the block pulse the acknowledge. Periodic refresh is scheduled from a cycle counter, and a refresh that has fallen due is issued before any waiting request.

Read data is sampled from the data bus at the edge set by the programmed CAS latency, which may be 2 or 3. All waits between commands are counted in clock cycles from parameters.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, and for PWRUP_CYC cycles after it is released, the command pins show NOP, clock enable is high, `init_done` is low and the data bus is not driven.
- R2: The start-up routine issues, in this order: PRECHARGE with A10=1; AUTO REFRESH T_RP cycles later; a second AUTO REFRESH T_RFC cycles after the first; and LOAD MODE T_RFC cycles after the second. LOAD MODE carries burst length 1 in A2:A0 (000), sequential order in A3 (0), the CAS latency in A6:A4, 00 in A8:A7 and single-beat writes in A9 (1), which gives 12'h220 for latency 2. `init_done` goes high in the cycle that LOAD MODE appears.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} are coded as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R4: A request address is split as {bank[21:20], row[19:8], column[7:0]}. ACTIVE puts the bank on BA and the row on A. READ or WRITE follows exactly T_RCD cycles later, with the same bank, the column on A7:A0, A10=1 and every other A bit at 0.
- R5: In the WRITE cycle the block drives the write data with `sd_dq_oe` high and sets DQM to the inverse of `req_be` (bit 0 is the low byte). `sd_dq_oe` is low in every other cycle, and the device keeps the bytes whose DQM bit is 1.
- R6: For a read, `rd_data` holds the word the device places on the bus CAS_LAT cycles after it registers READ. That value is valid in the cycle when `req_ack` is high.
- R7: `req_ack` is a one-cycle pulse. It rises T_WR+T_RP cycles after a WRITE appears on the pins, and CAS_LAT+1+T_RP cycles after a READ appears.
- R8: After start-up, an AUTO REFRESH falls due every REFI_CYC cycles. With no traffic, consecutive refreshes are exactly REFI_CYC cycles apart. A due refresh wins over a pending request, so even under back-to-back requests no gap between refreshes exceeds REFI_CYC plus one access.
- R9: After any AUTO REFRESH, no command other than NOP appears for T_RFC-1 cycles.
- R10: No ACTIVE is issued while `init_done` is low, even when a request is already waiting.
- R11: DQM is 11 for every command except READ (00) and WRITE (per R5), and during NOP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; held until acknowledged |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for the write |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| init_done | output | 1 | Start-up routine finished |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Address / mode word |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data driven to the device |
| sd_dq_oe | output | 1 | Drive enable for the data bus |
| sd_dq_in | input | 16 | Data returned by the device |

## Verification
The assertions assume that the requester holds `req_valid` and its fields steady until `req_ack`, and that it never starts a second request before the first is acknowledged. The bench meets this by placing each request at a falling edge and changing it only in the cycle when the acknowledge is seen. The read-capture checks also assume that the device presents data exactly CAS_LAT cycles after it registers READ, and outside that cycle shows a distinct filler value. The behavioural memory in the bench follows that rule, so a capture that is one cycle off picks up the filler.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Bit order is {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IREF, ST_MRS, ST_IDLE, ST_RW, ST_DONE
  } seq_state_e;

  // One-beat bursts, sequential order, standard mode, single-beat writes
  function automatic logic [11:0] mode_word(input int cl);
    logic [11:0] m;
    m       = '0;
    m[6:4]  = 3'(cl);
    m[9]    = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sdram_seq_wait.sv
module sdram_seq_wait #(
  parameter int W       = 14,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_seq_refresh.sv
module sdram_seq_refresh #(
  parameter int REFI_CYC = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic due
);
  localparam int CW = $clog2(REFI_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= CW'(REFI_CYC - 1);
      due <= 1'b0;
    end else begin
      if (cnt == '0) cnt <= CW'(REFI_CYC - 1);
      else           cnt <= cnt - 1'b1;
      if (cnt == '0) due <= 1'b1;
      else if (clr)  due <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
  parameter int CAS_LAT = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data
);
  logic [CAS_LAT-1:0] sh;

  generate
    if (CAS_LAT > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[CAS_LAT-2:0], rd_issue};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= rd_issue;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (sh[CAS_LAT-1])   rd_data <= dq_in;
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 16,
  parameter int CAS_LAT   = 2,
  parameter int PWRUP_CYC = 10000,
  parameter int REFI_CYC  = 1560,
  parameter int INIT_REFS = 2,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 2,
  parameter int T_WR      = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_we,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  input  logic [DATA_W/8-1:0]             req_be,
  output logic                            req_ack,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            init_done,
  output logic                            sd_cke,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_a,
  output logic [DATA_W/8-1:0]             sd_dqm,
  output logic [DATA_W-1:0]               sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_in
);
  localparam int DQM_W   = DATA_W / 8;
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT  = 10;
  localparam int RD_WAIT = CAS_LAT + 1 + T_RP;
  localparam int WR_WAIT = T_WR + T_RP;
  localparam int LONGEST = (PWRUP_CYC > 64) ? PWRUP_CYC : 64;
  localparam int WAIT_W  = $clog2(LONGEST + 1);
  localparam int IREF_W  = $clog2(INIT_REFS + 1);

  seq_state_e          state, nxt;
  logic [IREF_W-1:0]   iref_n;
  logic                hold_we;
  logic [ADDR_W-1:0]   hold_addr;
  logic [DATA_W-1:0]   hold_wdata;
  logic [DQM_W-1:0]    hold_be;

  sd_cmd_e             cmd_q, c_cmd;
  logic [BANK_W-1:0]   ba_q, c_ba;
  logic [ROW_W-1:0]    a_q, c_a;
  logic [DQM_W-1:0]    dqm_q, c_dqm;
  logic [DATA_W-1:0]   dq_q, c_dq;
  logic                oe_q, c_oe, ack_q, c_ack, done_q;
  logic                ld, lat_req, ref_clr, tmr_zero, ref_due;
  logic [WAIT_W-1:0]   ld_val;

  sdram_seq_wait #(.W(WAIT_W), .RST_VAL(PWRUP_CYC - 1)) u_wait (
    .clk(clk), .rst(rst), .load(ld), .val(ld_val), .zero(tmr_zero));

  sdram_seq_refresh #(.REFI_CYC(REFI_CYC)) u_ref (
    .clk(clk), .rst(rst), .en(done_q), .clr(ref_clr), .due(ref_due));

  sdram_seq_rdcap #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rd_issue(cmd_q == CMD_RD),
    .dq_in(sd_dq_in), .rd_data(rd_data));

  always_comb begin
    nxt     = state;
    c_cmd   = CMD_NOP;
    c_ba    = '0;
    c_a     = '0;
    c_dqm   = '1;
    c_dq    = dq_q;
    c_oe    = 1'b0;
    c_ack   = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    lat_req = 1'b0;
    ref_clr = 1'b0;
    if (tmr_zero) begin
      unique case (state)
        ST_PWRUP: begin
          c_cmd = CMD_PRE; c_a[AP_BIT] = 1'b1;
          ld = 1'b1; ld_val = WAIT_W'(T_RP - 1); nxt = ST_IREF;
        end
        ST_IREF: begin
          c_cmd = CMD_REF; ld = 1'b1; ld_val = WAIT_W'(T_RFC - 1);
          if (iref_n == IREF_W'(INIT_REFS - 1)) nxt = ST_MRS;
        end
        ST_MRS: begin
          c_cmd = CMD_LMR; c_a = ROW_W'(mode_word(CAS_LAT));
          ld = 1'b1; ld_val = WAIT_W'(T_MRD - 1); nxt = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_due) begin
            c_cmd = CMD_REF; ref_clr = 1'b1;
            ld = 1'b1; ld_val = WAIT_W'(T_RFC - 1);
          end else if (req_valid) begin
            c_cmd = CMD_ACT; lat_req = 1'b1;
            c_ba  = req_addr[ADDR_W-1 -: BANK_W];
            c_a   = req_addr[COL_W +: ROW_W];
            ld = 1'b1; ld_val = WAIT_W'(T_RCD - 1); nxt = ST_RW;
          end
        end
        ST_RW: begin
          c_ba = hold_addr[ADDR_W-1 -: BANK_W];
          c_a[COL_W-1:0] = hold_addr[COL_W-1:0];
          c_a[AP_BIT]    = 1'b1;
          ld = 1'b1; nxt = ST_DONE;
          if (hold_we) begin
            c_cmd = CMD_WR; c_oe = 1'b1; c_dq = hold_wdata;
            c_dqm = ~hold_be; ld_val = WAIT_W'(WR_WAIT - 1);
          end else begin
            c_cmd = CMD_RD; c_dqm = '0; ld_val = WAIT_W'(RD_WAIT - 1);
          end
        end
        ST_DONE: begin
          c_ack = 1'b1; nxt = ST_IDLE;
        end
        default: nxt = ST_PWRUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_PWRUP;  iref_n <= '0;   cmd_q <= CMD_NOP;
      ba_q  <= '0;        a_q    <= '0;   dqm_q <= '1;
      dq_q  <= '0;        oe_q   <= 1'b0; ack_q <= 1'b0;
      done_q <= 1'b0;     hold_we <= 1'b0; hold_addr <= '0;
      hold_wdata <= '0;   hold_be <= '0;
    end else begin
      state <= nxt;   cmd_q <= c_cmd; ba_q <= c_ba; a_q <= c_a;
      dqm_q <= c_dqm; dq_q  <= c_dq;  oe_q <= c_oe; ack_q <= c_ack;
      if (state == ST_IREF && tmr_zero) iref_n <= iref_n + 1'b1;
      if (state == ST_MRS && tmr_zero)  done_q <= 1'b1;
      if (lat_req) begin
        hold_we <= req_we;     hold_addr <= req_addr;
        hold_wdata <= req_wdata; hold_be <= req_be;
      end
    end
  end

  assign sd_cke    = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign req_ack   = ack_q;
  assign init_done = done_q;
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk
  import sdram_seq_pkg::*;
#(
  parameter int T_RFC = 7,
  parameter int T_RCD = 2,
  parameter int DQM_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [DQM_W-1:0] sd_dqm,
  input logic             sd_dq_oe,
  input logic             init_done,
  input logic             req_ack
);
  logic [3:0] cmd;
  logic [7:0] since_ref, since_act;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ref <= 8'hFF;
      since_act <= 8'hFF;
    end else begin
      since_ref <= (cmd == CMD_REF) ? 8'd1 : ((since_ref == 8'hFF) ? since_ref : since_ref + 8'd1);
      since_act <= (cmd == CMD_ACT) ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
    end
  end

  // R9: refresh recovery window holds off every other command
  a_r9_rfc_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |-> (since_ref >= 8'(T_RFC)));

  // R4: column command exactly T_RCD after the row command
  a_r4_rcd_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |-> (since_act == 8'(T_RCD)));

  // R5: data bus driven only alongside WRITE
  a_r5_oe_write_only: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (cmd == CMD_WR));

  // R7: acknowledge lasts one cycle
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R10: no row opened before start-up completes
  a_r10_no_act_early: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (cmd != CMD_ACT));

  // R11: masks high outside column commands
  a_r11_dqm_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_RD && cmd != CMD_WR) |-> (sd_dqm == '1));
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
  .T_RFC(T_RFC), .T_RCD(T_RCD), .DQM_W(DATA_W/8)
) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm),
  .sd_dq_oe(sd_dq_oe), .init_done(init_done), .req_ack(req_ack)
);

// File: tb/sdram_seq_ctrl_test.sv
module sdram_seq_ctrl_test;
  import sdram_seq_pkg::*;

  localparam int PWR = 10000, REFI = 1560, TRP = 2, TRFC = 7;
  localparam int TMRD = 2, TRCD = 2, TWR = 2, CL = 2;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_we = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ack, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [15:0] sd_dq_in = 16'hDEAD;
  logic [1:0]  sd_ba, sd_dqm;
  logic [11:0] sd_a;

  sdram_seq_ctrl #(.CAS_LAT(CL), .PWRUP_CYC(PWR), .REFI_CYC(REFI), .T_RP(TRP),
    .T_RFC(TRFC), .T_MRD(TMRD), .T_RCD(TRCD), .T_WR(TWR)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack), .rd_data(rd_data),
    .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  // Behavioural device: registers commands at the rising edge
  logic [15:0] mem [int];
  logic [11:0] open_row = '0;
  logic [15:0] rword = '0;
  int          rem = 0;
  always @(posedge clk) begin
    int k;
    logic [15:0] w;
    if (rem != 0) rem <= rem - 1;
    if (rem == 2) sd_dq_in <= rword;
    else if (rem == 1) sd_dq_in <= 16'hDEAD;
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      CMD_ACT: open_row <= sd_a;
      CMD_WR: begin
        k = int'({sd_ba, open_row, sd_a[7:0]});
        w = mem.exists(k) ? mem[k] : 16'h0;
        if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
        if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
        mem[k] = w;
      end
      CMD_RD: begin
        k = int'({sd_ba, open_row, sd_a[7:0]});
        rword <= mem.exists(k) ? mem[k] : 16'h0;
        rem <= CL;
      end
      default: ;
    endcase
  end

  // Scoreboard of outstanding requests
  typedef struct { bit we; logic [21:0] addr; logic [15:0] data; logic [1:0] be; logic [15:0] rexp; } desc_t;
  desc_t       sb[$];
  logic [15:0] emem [int];

  // Protocol monitor
  int first_cmd = -1, n_ilog = 0, last_ref = -1000, last_act = 0, last_rw = 0;
  int ilog_cyc[4];
  logic [3:0]  ilog_cmd[4];
  logic [11:0] ilog_a[4];
  bit last_rd = 0, prev_ack = 0;
  int ref_prev = -1, last_gap = 0, max_gap = 0, n_ref = 0;

  always @(negedge clk) if (!rst) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (c != CMD_NOP) begin
      if (first_cmd < 0) first_cmd = cyc;
      if (n_ilog < 4) begin
        ilog_cyc[n_ilog] = cyc; ilog_cmd[n_ilog] = c; ilog_a[n_ilog] = sd_a; n_ilog++;
      end
      if (cyc - last_ref < TRFC) chk(0, "R9", "command inside refresh recovery", cyc - last_ref, TRFC);
      if (c != CMD_RD && c != CMD_WR) chk(sd_dqm == 2'b11, "R11", "dqm on non-column command", sd_dqm, 3);
    end
    case (c)
      CMD_REF: begin
        if (init_done) begin
          if (ref_prev >= 0) begin
            last_gap = cyc - ref_prev;
            if (last_gap > max_gap) max_gap = last_gap;
          end
          ref_prev = cyc; n_ref++;
        end
        last_ref = cyc;
      end
      CMD_ACT: begin
        last_act = cyc;
        chk(init_done, "R10", "ACTIVE before init_done", 0, 1);
        if (sb.size() > 0) begin
          chk(sd_ba == sb[0].addr[21:20], "R4", "ACTIVE bank", sd_ba, sb[0].addr[21:20]);
          chk(sd_a == sb[0].addr[19:8], "R4", "ACTIVE row", sd_a, sb[0].addr[19:8]);
        end
      end
      CMD_RD, CMD_WR: begin
        last_rw = cyc; last_rd = (c == CMD_RD);
        chk(cyc - last_act == TRCD, "R4", "ACTIVE to column gap", cyc - last_act, TRCD);
        if (sb.size() > 0) begin
          chk(sd_a == {1'b0, 1'b1, 2'b00, sb[0].addr[7:0]}, "R4", "column address word",
              sd_a, {1'b0, 1'b1, 2'b00, sb[0].addr[7:0]});
          chk(sd_ba == sb[0].addr[21:20], "R4", "column bank", sd_ba, sb[0].addr[21:20]);
          chk(last_rd == !sb[0].we, "R3", "column command code", c, sb[0].we ? 4 : 5);
          if (c == CMD_WR) begin
            chk(sd_dq_oe && sd_dq_out == sb[0].data, "R5", "write data", sd_dq_out, sb[0].data);
            chk(sd_dqm == ~sb[0].be, "R5", "write masks", sd_dqm, ~sb[0].be);
          end else chk(sd_dqm == 2'b00, "R11", "read masks", sd_dqm, 0);
        end
      end
      default: ;
    endcase
    if (sd_dq_oe && c != CMD_WR) chk(0, "R5", "bus driven outside WRITE", c, 4);
    if (req_ack) begin
      chk(!prev_ack, "R7", "ack longer than one cycle", 1, 0);
      chk(cyc - last_rw == (last_rd ? CL + 1 + TRP : TWR + TRP), "R7", "ack delay",
          cyc - last_rw, last_rd ? CL + 1 + TRP : TWR + TRP);
      if (sb.size() > 0) begin
        if (!sb[0].we) chk(rd_data == sb[0].rexp, "R6", "read data", rd_data, sb[0].rexp);
        void'(sb.pop_front());
      end
    end
    prev_ack = req_ack;
  end

  // Driver: request stays valid until its acknowledge
  task automatic issue(bit we, logic [21:0] addr, logic [15:0] data, logic [1:0] be);
    desc_t d;
    logic [15:0] w;
    int k;
    k = int'(addr);
    w = emem.exists(k) ? emem[k] : 16'h0;
    d.we = we; d.addr = addr; d.data = data; d.be = be; d.rexp = w;
    if (we) begin
      if (be[0]) w[7:0]  = data[7:0];
      if (be[1]) w[15:8] = data[15:8];
      emem[k] = w;
    end
    sb.push_back(d);
    req_valid = 1; req_we = we; req_addr = addr; req_wdata = data; req_be = be;
    do @(negedge clk); while (!req_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R1", "command in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, CMD_NOP);
    chk(sd_cke && !init_done && !sd_dq_oe, "R1", "cke/init_done/oe in reset",
        {sd_cke, init_done, sd_dq_oe}, 3'b100);
    rst = 0;
    @(negedge clk);
    // R10: request waits behind start-up
    issue(1, {2'd1, 12'h123, 8'h45}, 16'h1234, 2'b11);
    chk(first_cmd >= PWR && first_cmd <= PWR + 1, "R1", "quiet period length", first_cmd, PWR);
    chk(ilog_cmd[0] == CMD_PRE && ilog_a[0][10], "R2", "first command precharge-all", ilog_cmd[0], CMD_PRE);
    chk(ilog_cmd[1] == CMD_REF && ilog_cyc[1] - ilog_cyc[0] == TRP, "R2", "first refresh spacing",
        ilog_cyc[1] - ilog_cyc[0], TRP);
    chk(ilog_cmd[2] == CMD_REF && ilog_cyc[2] - ilog_cyc[1] == TRFC, "R2", "second refresh spacing",
        ilog_cyc[2] - ilog_cyc[1], TRFC);
    chk(ilog_cmd[3] == CMD_LMR && ilog_cyc[3] - ilog_cyc[2] == TRFC, "R3", "load mode code and spacing",
        ilog_cmd[3], CMD_LMR);
    chk(ilog_a[3] == 12'h220, "R2", "mode word", ilog_a[3], 12'h220);
    issue(0, {2'd1, 12'h123, 8'h45}, 16'h0, 2'b00);
    // R5: byte masks merge
    issue(1, {2'd1, 12'h123, 8'h45}, 16'hABCD, 2'b01);
    issue(0, {2'd1, 12'h123, 8'h45}, 16'h0, 2'b00);
    issue(1, {2'd1, 12'h123, 8'h45}, 16'h9900, 2'b10);
    issue(0, {2'd1, 12'h123, 8'h45}, 16'h0, 2'b00);
    // R4: extreme bank/row/column
    issue(1, {2'd3, 12'hFFF, 8'hFF}, 16'h5AA5, 2'b11);
    issue(1, {2'd0, 12'h000, 8'h00}, 16'hC3C3, 2'b11);
    issue(0, {2'd3, 12'hFFF, 8'hFF}, 16'h0, 2'b00);
    issue(0, {2'd0, 12'h000, 8'h00}, 16'h0, 2'b00);
    req_valid = 0;
    // R8: idle refresh period
    repeat (3 * REFI + 10) @(negedge clk);
    chk(last_gap == REFI, "R8", "idle refresh period", last_gap, REFI);
    // R8: refresh wins over a continuous request stream
    max_gap = 0; n_ref = 0;
    for (int i = 0; i < 800; i++) begin
      logic [21:0] ad;
      ad = 22'((i * 32'd2654435761) >> 7);
      issue(1, ad, 16'(i * 7 + 3), 2'b11);
      issue(0, ad, 16'h0, 2'b00);
    end
    req_valid = 0;
    chk(n_ref >= 6, "R8", "refreshes under traffic", n_ref, 6);
    chk(max_gap <= REFI + 12, "R8", "largest refresh gap under traffic", max_gap, REFI + 12);
    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R7", "requests left unacknowledged", sb.size(), 0);
    finish_run();
  end
endmodule